// File: doc/BRIEF.md
# Wormhole Header Router

This block sits between three bidirectional byte-stream links and the local node's receive path. Each packet that arrives on a link starts with a one-byte destination. The router reads that byte, drops it, and steers the rest of the packet to one of the other two links or to the local receive output. Every link has its own programmable 8-bit address, and so does the node.

The chosen path is reserved from the moment it is granted until the packet's end token has gone through. This works like a wormhole: a second packet that wants the same output waits under ready/valid backpressure. A destination that matches no address sends the packet to the local output and sets a sticky error bit for the arrival link. The error can raise an interrupt through a mask.

Tokens are 8-bit data bytes with an end flag. When the flag is set, bit 0 of the data byte tells the two end-token kinds apart. Routing can be turned off at the start of a packet. The whole packet, first byte included, then goes to the local output.

Top module: `wh_router`

## Requirements
- R1: After reset, every link output and the local output show no valid token, all error status bits read 0, and the interrupt output is low.
- R2: A first byte equal to another link's address is consumed and not forwarded. The following bytes and the end token (end flag 1, data byte unchanged, bit 0 = 0 for the first kind and 1 for the second) go out on that link in order, under output backpressure.
- R3: A first byte equal to the node address sends the rest of the packet to the local output, without the first byte. The local source field gives the arrival link index (0, 1 or 2).
- R4: A first byte that matches no address sends the rest of the packet to the local output. It also sets the error status bit whose index is the arrival link.
- R5: A first byte equal only to the arrival link's own address is handled as no match: the packet goes to the local output and the error bit is set.
- R6: When addresses collide, the node address wins over any link address, and among link addresses the lowest link index wins.
- R7: An output stays reserved for one input until that packet's end token has been accepted. Another input whose packet targets it holds in_ready low after its first byte and is served once the output is released.
- R8: When two inputs request the same free output in the same cycle, the lower-indexed input is served first, and the other packet follows afterwards in full.
- R9: Error status bits stay set until a 1 is written to the matching clear bit. The interrupt is the OR of status AND mask, so a masked bit still records status.
- R10: With routing disabled when a packet starts, the whole packet, first byte included, goes to the local output and no error is flagged.
- R11: An end token that arrives where a first byte is expected is consumed and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| route_en_i | input | 1 | Header routing enable, sampled at packet start |
| node_addr_i | input | DATA_W | Local node address |
| link_addr_i | input | NUM_LINKS*DATA_W | Address of each link, link k at bits k*DATA_W |
| in_valid_i | input | NUM_LINKS | Incoming token valid, per link |
| in_data_i | input | NUM_LINKS*DATA_W | Incoming token byte, per link |
| in_eop_i | input | NUM_LINKS | Incoming token is an end token |
| in_ready_o | output | NUM_LINKS | Incoming token accepted |
| out_valid_o | output | NUM_LINKS | Outgoing link token valid |
| out_data_o | output | NUM_LINKS*DATA_W | Outgoing link token byte |
| out_eop_o | output | NUM_LINKS | Outgoing link token is an end token |
| out_ready_i | input | NUM_LINKS | Outgoing link can accept |
| loc_valid_o | output | 1 | Local receive token valid |
| loc_data_o | output | DATA_W | Local receive token byte |
| loc_eop_o | output | 1 | Local receive token is an end token |
| loc_src_o | output | $clog2(NUM_LINKS) | Arrival link of the local packet |
| loc_ready_i | input | 1 | Local receive path can accept |
| err_mask_i | input | NUM_LINKS | Interrupt mask per error bit |
| err_clr_i | input | NUM_LINKS | Write 1 to clear error bit |
| err_stat_o | output | NUM_LINKS | Sticky unknown-destination status per link |
| irq_o | output | 1 | Error interrupt |

## Verification
The hardest state to reach from the ports is an input that has already had its first byte taken and is waiting while another packet holds its output. The stimulus holds that output's ready low so the first packet stalls mid-flight. It then launches the second packet and samples in_ready in the waiting window before it releases the output. Headers that arrive in the same cycle are produced by starting two drivers on the same clock edge. Address collisions are produced by reprogramming link addresses between packets.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_WAIT = 2'd1,
    ST_FWD  = 2'd2
  } in_st_e;
endpackage

// File: rtl/wh_hdr_dec.sv
module wh_hdr_dec #(
  parameter int NUM_LINKS = 3,
  parameter int DATA_W    = 8,
  parameter int SELF      = 0,
  parameter int DST_W     = 2
) (
  input  logic [DATA_W-1:0]           hdr_i,
  input  logic [DATA_W-1:0]           node_addr_i,
  input  logic [NUM_LINKS*DATA_W-1:0] link_addr_i,
  output logic [DST_W-1:0]            dst_o,
  output logic                        miss_o
);
  localparam int LOC_IDX = NUM_LINKS;

  always_comb begin
    dst_o  = DST_W'(LOC_IDX);
    miss_o = 1'b1;
    if (hdr_i == node_addr_i) begin
      miss_o = 1'b0;
    end else begin
      // descending scan: lowest matching link is written last
      for (int j = NUM_LINKS - 1; j >= 0; j--) begin
        if (j != SELF && hdr_i == link_addr_i[j*DATA_W +: DATA_W]) begin
          dst_o  = DST_W'(j);
          miss_o = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wh_in_ctl.sv
module wh_in_ctl import wh_pkg::*; #(
  parameter int DST_W   = 2,
  parameter int LOC_IDX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             route_en_i,
  input  logic             in_valid_i,
  input  logic             in_eop_i,
  input  logic [DST_W-1:0] dec_dst_i,
  input  logic             dec_miss_i,
  input  logic             gnt_i,
  input  logic             sel_ready_i,
  output logic             in_ready_o,
  output logic             req_o,
  output logic [DST_W-1:0] dst_o,
  output logic             miss_o
);
  in_st_e           st_q, st_d;
  logic [DST_W-1:0] dst_q, dst_d;
  logic             hdr_fire;

  assign hdr_fire   = (st_q == ST_HDR) && route_en_i && in_valid_i;
  assign in_ready_o = ((st_q == ST_HDR) && route_en_i) || ((st_q == ST_FWD) && sel_ready_i);
  assign req_o      = (st_q == ST_WAIT);
  assign dst_o      = dst_q;
  assign miss_o     = hdr_fire && !in_eop_i && dec_miss_i;

  always_comb begin
    st_d  = st_q;
    dst_d = dst_q;
    unique case (st_q)
      ST_HDR: begin
        if (in_valid_i) begin
          if (!route_en_i) begin
            st_d  = ST_WAIT;
            dst_d = DST_W'(LOC_IDX);
          end else if (!in_eop_i) begin
            st_d  = ST_WAIT;
            dst_d = dec_dst_i;
          end
        end
      end
      ST_WAIT: if (gnt_i) st_d = ST_FWD;
      ST_FWD:  if (in_valid_i && sel_ready_i && in_eop_i) st_d = ST_HDR;
      default: st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HDR;
      dst_q <= DST_W'(LOC_IDX);
    end else begin
      st_q  <= st_d;
      dst_q <= dst_d;
    end
  end

  // R10
  bypass_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR && !route_en_i && in_valid_i) |=> (st_q == ST_WAIT && dst_q == DST_W'(LOC_IDX)));

  // R11
  lone_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR && route_en_i && in_valid_i && in_eop_i) |=> (st_q == ST_HDR));
endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc #(
  parameter int NUM_LINKS = 3,
  parameter int SRC_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINKS-1:0] req_i,
  input  logic                 release_i,
  output logic [NUM_LINKS-1:0] gnt_o,
  output logic                 busy_o,
  output logic [SRC_W-1:0]     owner_o
);
  logic             busy_q;
  logic [SRC_W-1:0] owner_q, pick;

  always_comb begin
    gnt_o = '0;
    pick  = owner_q;
    for (int j = NUM_LINKS - 1; j >= 0; j--) begin
      if (!busy_q && req_i[j]) begin
        gnt_o    = '0;
        gnt_o[j] = 1'b1;
        pick     = SRC_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (release_i) begin
      busy_q  <= 1'b0;
    end else if (gnt_o != '0) begin
      busy_q  <= 1'b1;
      owner_q <= pick;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !release_i) |=> (busy_q && $stable(owner_q)));
endmodule

// File: rtl/wh_err_irq.sv
module wh_err_irq #(
  parameter int NUM_LINKS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINKS-1:0] set_i,
  input  logic [NUM_LINKS-1:0] clr_i,
  input  logic [NUM_LINKS-1:0] mask_i,
  output logic [NUM_LINKS-1:0] stat_o,
  output logic                 irq_o
);
  logic [NUM_LINKS-1:0] stat_q;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);

  // R4
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != '0) |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0));
endmodule

// File: rtl/wh_router.sv
module wh_router import wh_pkg::*; #(
  parameter int NUM_LINKS = 3,
  parameter int DATA_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          route_en_i,
  input  logic [DATA_W-1:0]             node_addr_i,
  input  logic [NUM_LINKS*DATA_W-1:0]   link_addr_i,
  input  logic [NUM_LINKS-1:0]          in_valid_i,
  input  logic [NUM_LINKS*DATA_W-1:0]   in_data_i,
  input  logic [NUM_LINKS-1:0]          in_eop_i,
  output logic [NUM_LINKS-1:0]          in_ready_o,
  output logic [NUM_LINKS-1:0]          out_valid_o,
  output logic [NUM_LINKS*DATA_W-1:0]   out_data_o,
  output logic [NUM_LINKS-1:0]          out_eop_o,
  input  logic [NUM_LINKS-1:0]          out_ready_i,
  output logic                          loc_valid_o,
  output logic [DATA_W-1:0]             loc_data_o,
  output logic                          loc_eop_o,
  output logic [$clog2(NUM_LINKS)-1:0]  loc_src_o,
  input  logic                          loc_ready_i,
  input  logic [NUM_LINKS-1:0]          err_mask_i,
  input  logic [NUM_LINKS-1:0]          err_clr_i,
  output logic [NUM_LINKS-1:0]          err_stat_o,
  output logic                          irq_o
);
  localparam int NUM_DST = NUM_LINKS + 1;
  localparam int DST_W   = $clog2(NUM_DST);
  localparam int SRC_W   = $clog2(NUM_LINKS);
  localparam int LOC_IDX = NUM_LINKS;

  logic [DST_W-1:0]     dec_dst [NUM_LINKS];
  logic [DST_W-1:0]     cur_dst [NUM_LINKS];
  logic [NUM_LINKS-1:0] dec_miss, req, gnt_in, miss_set, sel_ready;
  logic [NUM_LINKS-1:0] req_m [NUM_DST];
  logic [NUM_LINKS-1:0] gnt_m [NUM_DST];
  logic [SRC_W-1:0]     owner [NUM_DST];
  logic [DATA_W-1:0]    dst_data [NUM_DST];
  logic [NUM_DST-1:0]   busy, dst_valid, dst_eop, dst_ready, release_d;

  assign dst_ready = {loc_ready_i, out_ready_i};

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_in
    wh_hdr_dec #(
      .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .SELF(i), .DST_W(DST_W)
    ) u_dec (
      .hdr_i      (in_data_i[i*DATA_W +: DATA_W]),
      .node_addr_i(node_addr_i),
      .link_addr_i(link_addr_i),
      .dst_o      (dec_dst[i]),
      .miss_o     (dec_miss[i])
    );

    assign sel_ready[i] = dst_ready[cur_dst[i]];

    wh_in_ctl #(.DST_W(DST_W), .LOC_IDX(LOC_IDX)) u_ctl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .route_en_i (route_en_i),
      .in_valid_i (in_valid_i[i]),
      .in_eop_i   (in_eop_i[i]),
      .dec_dst_i  (dec_dst[i]),
      .dec_miss_i (dec_miss[i]),
      .gnt_i      (gnt_in[i]),
      .sel_ready_i(sel_ready[i]),
      .in_ready_o (in_ready_o[i]),
      .req_o      (req[i]),
      .dst_o      (cur_dst[i]),
      .miss_o     (miss_set[i])
    );
  end

  always_comb begin
    gnt_in = '0;
    for (int i = 0; i < NUM_LINKS; i++)
      for (int d = 0; d < NUM_DST; d++)
        gnt_in[i] = gnt_in[i] | gnt_m[d][i];
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    always_comb begin
      for (int i = 0; i < NUM_LINKS; i++)
        req_m[d][i] = req[i] && (cur_dst[i] == DST_W'(d));
    end

    wh_out_alloc #(.NUM_LINKS(NUM_LINKS), .SRC_W(SRC_W)) u_alloc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_m[d]),
      .release_i(release_d[d]),
      .gnt_o    (gnt_m[d]),
      .busy_o   (busy[d]),
      .owner_o  (owner[d])
    );

    assign dst_valid[d] = busy[d] && in_valid_i[owner[d]];
    assign dst_eop[d]   = in_eop_i[owner[d]];
    assign dst_data[d]  = in_data_i[int'(owner[d])*DATA_W +: DATA_W];
    assign release_d[d] = dst_valid[d] && dst_ready[d] && dst_eop[d];

    if (d < NUM_LINKS) begin : g_link
      assign out_valid_o[d]                = dst_valid[d];
      assign out_eop_o[d]                  = dst_eop[d];
      assign out_data_o[d*DATA_W +: DATA_W] = dst_data[d];

      // R5
      no_loopback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy[d] |-> (int'(owner[d]) != d));
    end
  end

  assign loc_valid_o = dst_valid[LOC_IDX];
  assign loc_eop_o   = dst_eop[LOC_IDX];
  assign loc_data_o  = dst_data[LOC_IDX];
  assign loc_src_o   = owner[LOC_IDX];

  wh_err_irq #(.NUM_LINKS(NUM_LINKS)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (miss_set),
    .clr_i (err_clr_i),
    .mask_i(err_mask_i),
    .stat_o(err_stat_o),
    .irq_o (irq_o)
  );
endmodule

// File: tb/wh_router_tb.sv
`timescale 1ns/1ps
module wh_router_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       route_en = 1'b1;
  logic [7:0] node_addr = 8'h40;
  logic [7:0] laddr [3];
  logic [2:0] drv_valid = '0;
  logic [2:0] drv_eop = '0;
  logic [7:0] drv_data [3];
  logic [3:0] rdy = 4'hF;
  logic [2:0] mask = '0;
  logic [2:0] clr = '0;

  logic [2:0]  in_ready, out_valid, out_eop, err_stat;
  logic [23:0] out_data;
  logic        loc_valid, loc_eop, irq;
  logic [7:0]  loc_data;
  logic [1:0]  loc_src;

  int main_chk = 0, main_fail = 0, mon_chk = 0, mon_fail = 0;
  string cur_req = "R1";
  logic [10:0] exp_q [4][$];

  always #4 clk = ~clk;

  wh_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .route_en_i(route_en),
    .node_addr_i(node_addr), .link_addr_i({laddr[2], laddr[1], laddr[0]}),
    .in_valid_i(drv_valid), .in_data_i({drv_data[2], drv_data[1], drv_data[0]}),
    .in_eop_i(drv_eop), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_eop_o(out_eop),
    .out_ready_i(rdy[2:0]),
    .loc_valid_o(loc_valid), .loc_data_o(loc_data), .loc_eop_o(loc_eop),
    .loc_src_o(loc_src), .loc_ready_i(rdy[3]),
    .err_mask_i(mask), .err_clr_i(clr), .err_stat_o(err_stat), .irq_o(irq)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    main_chk++;
    if (!ok) begin
      main_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_tok(int i, logic e, logic [7:0] d);
    bit ok;
    drv_valid[i] = 1'b1; drv_eop[i] = e; drv_data[i] = d;
    do begin
      #3; ok = in_ready[i];
      @(negedge clk);
    end while (!ok);
    drv_valid[i] = 1'b0; drv_eop[i] = 1'b0;
  endtask

  task automatic send_pkt(int i, logic [7:0] hdr, logic [7:0] base, int n, logic kind);
    send_tok(i, 1'b0, hdr);
    for (int k = 0; k < n; k++) send_tok(i, 1'b0, base + 8'(k));
    send_tok(i, 1'b1, {7'd0, kind});
  endtask

  // expected stream of one packet at output d; first byte kept when keep_hdr
  task automatic exp_pkt(int d, int src, bit keep_hdr, logic [7:0] hdr,
                         logic [7:0] base, int n, logic kind);
    if (keep_hdr) exp_q[d].push_back({2'(src), 1'b0, hdr});
    for (int k = 0; k < n; k++) exp_q[d].push_back({2'(src), 1'b0, base + 8'(k)});
    exp_q[d].push_back({2'(src), 1'b1, {7'd0, kind}});
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size()) != 0 && t < 500) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 4; d++) chk(exp_q[d].size() == 0, cur_req, exp_q[d].size(), 0);
  endtask

  // per-cycle compare of every output handshake against the reference queues
  initial begin
    logic [10:0] got, e;
    bit v;
    forever begin
      @(negedge clk); #3;
      if (rst_n) begin
        for (int d = 0; d < 4; d++) begin
          if (d < 3) begin
            v = out_valid[d]; got = {2'd0, out_eop[d], out_data[d*8 +: 8]};
          end else begin
            v = loc_valid; got = {loc_src, loc_eop, loc_data};
          end
          if (v && rdy[d]) begin
            mon_chk++;
            if (exp_q[d].size() == 0) begin
              mon_fail++;
              $display("FAIL %s out%0d unexpected act=%h exp=none", cur_req, d, got);
            end else begin
              e = exp_q[d].pop_front();
              if (d < 3) e[10:9] = 2'd0;
              if (got !== e) begin
                mon_fail++;
                $display("FAIL %s out%0d act=%h exp=%h", cur_req, d, got, e);
              end
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==",
             main_chk + mon_chk + 1, main_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    laddr[0] = 8'h10; laddr[1] = 8'h21; laddr[2] = 8'h32;
    for (int i = 0; i < 3; i++) drv_data[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 3'b000 && !loc_valid, "R1", {out_valid, loc_valid}, 0);
    chk(err_stat == 3'b000 && !irq, "R1", {err_stat, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 3'b000 && !loc_valid && !irq, "R1", {out_valid, loc_valid, irq}, 0);

    // R2 link0 -> link1, first kind of end token
    cur_req = "R2";
    exp_pkt(1, 0, 0, 8'h00, 8'hA0, 3, 1'b0);
    send_pkt(0, 8'h21, 8'hA0, 3, 1'b0);
    drain();

    // R2 link2 -> link0 under toggling backpressure, second kind
    exp_pkt(0, 2, 0, 8'h00, 8'hB0, 5, 1'b1);
    fork
      send_pkt(2, 8'h10, 8'hB0, 5, 1'b1);
      for (int c = 0; c < 16; c++) begin rdy[0] = c[0]; @(negedge clk); end
    join
    rdy[0] = 1'b1;
    drain();

    // R3 link1 -> node, source index 1
    cur_req = "R3";
    exp_pkt(3, 1, 0, 8'h00, 8'hC0, 2, 1'b0);
    send_pkt(1, 8'h40, 8'hC0, 2, 1'b0);
    drain();
    chk(err_stat == 3'b000, "R3", err_stat, 0);

    // R4 unknown destination from link0
    cur_req = "R4";
    exp_pkt(3, 0, 0, 8'h00, 8'hD0, 2, 1'b1);
    send_pkt(0, 8'h99, 8'hD0, 2, 1'b1);
    drain();
    chk(err_stat == 3'b001, "R4", err_stat, 1);
    // R9 masked bit records status but no interrupt
    chk(!irq, "R9", irq, 0);
    mask = 3'b001; #1;
    chk(irq, "R9", irq, 1);

    // R5 link1 targets its own address
    cur_req = "R5";
    exp_pkt(3, 1, 0, 8'h00, 8'hE0, 1, 1'b0);
    send_pkt(1, 8'h21, 8'hE0, 1, 1'b0);
    drain();
    chk(err_stat == 3'b011, "R5", err_stat, 3);

    // R9 clear bit0 only; sticky bit1 stays
    cur_req = "R9";
    clr = 3'b001; @(negedge clk); clr = 3'b000; @(negedge clk);
    chk(err_stat == 3'b010, "R9", err_stat, 2);
    chk(!irq, "R9", irq, 0);
    mask = 3'b010; #1;
    chk(irq, "R9", irq, 1);
    clr = 3'b010; @(negedge clk); clr = 3'b000; @(negedge clk);
    chk(err_stat == 3'b000 && !irq, "R9", {err_stat, irq}, 0);

    // R6 node address wins over an equal link address
    cur_req = "R6";
    laddr[2] = 8'h40;
    exp_pkt(3, 0, 0, 8'h00, 8'h11, 2, 1'b0);
    send_pkt(0, 8'h40, 8'h11, 2, 1'b0);
    drain();
    laddr[2] = 8'h32; laddr[1] = 8'h32;
    // R6 lowest link index wins
    exp_pkt(1, 0, 0, 8'h00, 8'h22, 2, 1'b1);
    send_pkt(0, 8'h32, 8'h22, 2, 1'b1);
    drain();
    laddr[1] = 8'h21;
    chk(err_stat == 3'b000, "R6", err_stat, 0);

    // R7 output held by link0 while link1 waits
    cur_req = "R7";
    rdy[2] = 1'b0;
    exp_pkt(2, 0, 0, 8'h00, 8'h50, 4, 1'b0);
    exp_pkt(2, 1, 0, 8'h00, 8'h60, 2, 1'b1);
    fork
      send_pkt(0, 8'h32, 8'h50, 4, 1'b0);
      begin repeat (3) @(negedge clk); send_pkt(1, 8'h32, 8'h60, 2, 1'b1); end
      begin
        repeat (9) @(negedge clk); #3;
        chk(!in_ready[1], "R7", in_ready[1], 0);
        chk(out_valid[2] && out_data[23:16] == 8'h50, "R7", out_data[23:16], 8'h50);
        @(negedge clk); rdy[2] = 1'b1;
      end
    join
    drain();

    // R8 simultaneous requests for link0
    cur_req = "R8";
    exp_pkt(0, 1, 0, 8'h00, 8'h70, 3, 1'b0);
    exp_pkt(0, 2, 0, 8'h00, 8'h80, 3, 1'b1);
    fork
      send_pkt(1, 8'h10, 8'h70, 3, 1'b0);
      send_pkt(2, 8'h10, 8'h80, 3, 1'b1);
    join
    drain();

    // R10 routing disabled keeps first byte
    cur_req = "R10";
    route_en = 1'b0;
    exp_pkt(3, 2, 1, 8'h10, 8'h90, 1, 1'b0);
    send_pkt(2, 8'h10, 8'h90, 1, 1'b0);
    drain();
    route_en = 1'b1;
    chk(err_stat == 3'b000, "R10", err_stat, 0);

    // R11 stray end token produces nothing, next packet intact
    cur_req = "R11";
    send_tok(0, 1'b1, 8'h01);
    repeat (4) @(negedge clk);
    chk(out_valid == 3'b000 && !loc_valid, "R11", {out_valid, loc_valid}, 0);
    exp_pkt(2, 0, 0, 8'h00, 8'h33, 2, 1'b0);
    send_pkt(0, 8'h32, 8'h33, 2, 1'b0);
    drain();
    chk(err_stat == 3'b000, "R11", err_stat, 0);

    $display("  == %0d vectors applied, %0d miscompares ==",
             main_chk + mon_chk, main_fail + mon_fail);
    $finish;
  end
endmodule